// File: doc/BRIEF.md
# Registered Output Cell Bank with Power-Up Clear and Test Preload

This block is a bank of registered output cells for a small programmable-logic style device. Each cell holds one D flip-flop. The flip-flop is loaded from a per-cell logic input. It drives its pad through an inverting output stage that has a shared output enable. The pad is modelled as split signals: a driven level, a driver enable and a sensed level.

Two extra mechanisms sit around the flip-flops.

- **Power-up clear.** This window opens whenever the power-good input is low. It stays open for a fixed number of clock cycles after power-good rises, and during it every flip-flop is held at zero. Because the output stage inverts, every pad reads HIGH while the window is open. A further setup interval follows the window. During that interval clock edges still do not load the D inputs.
- **Test preload.** This path lets a tester force the register state from the pads. The tester first turns the drivers off and drives the pads. It then pulses the active-low preload strobe. On the trailing (rising) edge of the strobe, the inverse of each synchronised pad level is written into its flip-flop. As a result, the pad afterwards shows the same level the tester drove.

Top module: `regout_bank`

## Requirements
- R1: While the clear window is open, every flip-flop is zero, so every bit of `pin_o` is 1. The window is open while `rst_ni` is low, while `pwr_good_i` is low, and for `RST_CYCLES` rising clock edges after `pwr_good_i` goes high.
- R2: The clear window closes after exactly `RST_CYCLES` edges with `pwr_good_i` high. Two consequences follow from this:
  - A preload strobe whose rising edge is applied before edge `RST_CYCLES-1` is accepted.
  - A strobe applied one edge earlier is discarded.
  - Dropping `pwr_good_i` low reopens the window.
- R3: The D inputs are not loaded until `RST_CYCLES+SETUP_CYCLES` edges have passed since `pwr_good_i` rose. The first load happens on edge `RST_CYCLES+SETUP_CYCLES+1`.
- R4: Once loading is allowed and `oe_i` is 1, each rising edge loads `d_i`, and `pin_o` shows the bitwise inverse of `d_i`. Bit k of each bus belongs to cell k.
- R5: `pin_oe_o` has every bit equal to `oe_i`. While `oe_i` is 0, changes on `d_i` and clock edges leave the register contents, and hence `pin_o`, unchanged.
- R6: With `oe_i` at 0, a low-to-high transition of `preload_ni` stores the inverse of the synchronised `pin_i` into each flip-flop. After that, `pin_o` equals the `pin_i` pattern that was driven. This holds for all-zero, all-one and alternating patterns. The capture completes within `SYNC_STAGES+1` edges of the strobe's rising edge.
- R7: A preload strobe is ignored while `oe_i` is 1. In that case the cells keep loading `d_i`.
- R8: A preload strobe that lands inside the clear window is ignored, because the clear takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply good; low holds the bank in the clear window |
| d_i | input | NUM_CELLS | Per-cell logic input |
| oe_i | input | 1 | Output enable for all cells |
| preload_ni | input | 1 | Active-low preload strobe, asynchronous |
| pin_i | input | NUM_CELLS | Sensed pad level |
| pin_o | output | NUM_CELLS | Level driven onto the pads (inverse of the register) |
| pin_oe_o | output | NUM_CELLS | Pad driver enable per cell |

## Verification
The assertions assume `pwr_good_i`, `oe_i` and `d_i` change only away from the active clock edge. They also assume that `pin_i` stays constant while the preload strobe passes through the synchroniser. This matches the preload order: drivers off, pads driven, strobe, pads released. The bench drives every input on the falling edge. It holds the pad pattern from before the strobe falls until several cycles after it rises. It changes `oe_i` only while no strobe is in flight.

// File: rtl/regout_pkg.sv
package regout_pkg;
  typedef enum logic [1:0] {
    PH_CLEAR = 2'd0,
    PH_SETUP = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/pwrup_ctrl.sv
module pwrup_ctrl
  import regout_pkg::*;
#(
  parameter int RST_CYCLES   = 100,
  parameter int SETUP_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic clear_o,
  output logic upd_en_o
);
  localparam int TOTAL = RST_CYCLES + SETUP_CYCLES;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] RST_LIM = CW'(RST_CYCLES);
  localparam logic [CW-1:0] TOT_LIM = CW'(TOTAL);

  logic [CW-1:0] cnt_q;
  phase_e        phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!pwr_good_i)        cnt_q <= '0;
    else if (cnt_q != TOT_LIM)   cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q < RST_LIM)         phase = PH_CLEAR;
    else if (cnt_q < TOT_LIM)    phase = PH_SETUP;
    else                         phase = PH_RUN;
  end

  assign clear_o  = (phase == PH_CLEAR);
  assign upd_en_o = (phase == PH_RUN);
endmodule

// File: rtl/preload_sync.sv
module preload_sync #(
  parameter int NUM_CELLS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 preload_ni,
  input  logic [NUM_CELLS-1:0] pin_i,
  output logic                 load_o,
  output logic [NUM_CELLS-1:0] pin_sync_o
);
  logic [SYNC_STAGES-1:0] strb_q;
  logic                   strb_prev_q;
  logic [NUM_CELLS-1:0]   pin_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q      <= '1;
      strb_prev_q <= 1'b1;
    end else begin
      strb_q      <= {strb_q[SYNC_STAGES-2:0], preload_ni};
      strb_prev_q <= strb_q[SYNC_STAGES-1];
    end
  end

  // pad levels follow the same path depth as the strobe
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_pin_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pin_q[s] <= '0;
      else if (s == 0) pin_q[s] <= pin_i;
      else          pin_q[s] <= pin_q[(s == 0) ? 0 : s-1];
    end
  end

  assign load_o     = strb_q[SYNC_STAGES-1] & ~strb_prev_q;
  assign pin_sync_o = pin_q[SYNC_STAGES-1];
endmodule

// File: rtl/regout_cell.sv
module regout_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic upd_en_i,
  input  logic load_i,
  input  logic oe_i,
  input  logic d_i,
  input  logic pin_sync_i,
  output logic pin_o,
  output logic pin_oe_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q <= 1'b0;
    else if (clear_i)            q <= 1'b0;
    else if (load_i && !oe_i)    q <= ~pin_sync_i;  // matches output inverter
    else if (upd_en_i && oe_i)   q <= d_i;
  end

  assign pin_o    = ~q;
  assign pin_oe_o = oe_i;
endmodule

// File: rtl/regout_bank.sv
module regout_bank #(
  parameter int NUM_CELLS    = 10,
  parameter int RST_CYCLES   = 100,
  parameter int SETUP_CYCLES = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_good_i,
  input  logic [NUM_CELLS-1:0] d_i,
  input  logic                 oe_i,
  input  logic                 preload_ni,
  input  logic [NUM_CELLS-1:0] pin_i,
  output logic [NUM_CELLS-1:0] pin_o,
  output logic [NUM_CELLS-1:0] pin_oe_o
);
  logic                 reset_active;
  logic                 clk_en;
  logic                 load_pulse;
  logic [NUM_CELLS-1:0] pin_sync;

  pwrup_ctrl #(
    .RST_CYCLES  (RST_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES)
  ) pwrup_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_good_i(pwr_good_i),
    .clear_o   (reset_active),
    .upd_en_o  (clk_en)
  );

  preload_sync #(
    .NUM_CELLS  (NUM_CELLS),
    .SYNC_STAGES(SYNC_STAGES)
  ) psync_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .preload_ni(preload_ni),
    .pin_i     (pin_i),
    .load_o    (load_pulse),
    .pin_sync_o(pin_sync)
  );

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    regout_cell cell_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (reset_active),
      .upd_en_i  (clk_en),
      .load_i    (load_pulse),
      .oe_i      (oe_i),
      .d_i       (d_i[k]),
      .pin_sync_i(pin_sync[k]),
      .pin_o     (pin_o[k]),
      .pin_oe_o  (pin_oe_o[k])
    );
  end
endmodule

// File: rtl/regout_bank_chk.sv
module regout_bank_chk #(
  parameter int NUM_CELLS = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 pwr_good_i,
  input logic                 oe_i,
  input logic [NUM_CELLS-1:0] d_i,
  input logic [NUM_CELLS-1:0] pin_o,
  input logic                 reset_active,
  input logic                 clk_en,
  input logic                 load_pulse,
  input logic [NUM_CELLS-1:0] pin_sync
);
  AST_PWR_LOSS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> reset_active);  // R2
  AST_CLEAR_PINS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_active |=> (pin_o == '1));  // R1
  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en && !reset_active && !load_pulse) |=> $stable(pin_o));  // R3
  AST_RUN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en && oe_i) |=> (pin_o == ~$past(d_i)));  // R4
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_i && !load_pulse && !reset_active) |=> $stable(pin_o));  // R5
  AST_PRELOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_pulse && !oe_i && !reset_active) |=> (pin_o == $past(pin_sync)));  // R6
  AST_PRELOAD_OE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_pulse && oe_i && !clk_en && !reset_active) |=> $stable(pin_o));  // R7
endmodule

bind regout_bank regout_bank_chk #(.NUM_CELLS(NUM_CELLS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .oe_i        (oe_i),
  .d_i         (d_i),
  .pin_o       (pin_o),
  .reset_active(reset_active),
  .clk_en      (clk_en),
  .load_pulse  (load_pulse),
  .pin_sync    (pin_sync)
);

// File: tb/regout_bank_tb_top.sv
module regout_bank_tb_top;
  localparam int N     = 10;
  localparam int RSTC  = 100;
  localparam int SETC  = 3;
  localparam int SYNC  = 2;
  localparam int TOTAL = RSTC + SETC;
  localparam int NVEC  = 8;

  // {mode(1=preload,0=D load), data, expected pin_o}
  localparam logic [2*N:0] VEC [NVEC] = '{
    {1'b0, 10'h3FF, 10'h000},
    {1'b0, 10'h000, 10'h3FF},
    {1'b1, 10'h000, 10'h000},
    {1'b1, 10'h3FF, 10'h3FF},
    {1'b1, 10'h155, 10'h155},
    {1'b1, 10'h2AA, 10'h2AA},
    {1'b0, 10'h155, 10'h2AA},
    {1'b0, 10'h0F0, 10'h30F}
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pwr_good_i = 1'b0;
  logic [N-1:0] d_i = '0;
  logic         oe_i = 1'b0;
  logic         preload_ni = 1'b1;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pin_o;
  logic [N-1:0] pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  regout_bank #(
    .NUM_CELLS(N), .RST_CYCLES(RSTC), .SETUP_CYCLES(SETC), .SYNC_STAGES(SYNC)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i), .d_i(d_i),
    .oe_i(oe_i), .preload_ni(preload_ni), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_preload(logic [N-1:0] pat);
    oe_i = 1'b0; pin_i = pat; preload_ni = 1'b0;
    edges(3);
    preload_ni = 1'b1;
    edges(SYNC + 3);
    pin_i = ~pat;
  endtask

  initial begin
    edges(3);
    check("R1 reset pins high", pin_o, '1);
    rst_ni = 1'b1;
    edges(2);
    check("R1 pwr_good low pins high", pin_o, '1);
    // R3: D gated until TOTAL edges after power-good
    oe_i = 1'b1; d_i = '1; pwr_good_i = 1'b1;
    edges(TOTAL);
    check("R3 no load at edge TOTAL", pin_o, '1);
    check("R5 pin_oe follows oe", pin_oe_o, '1);
    edges(1);
    check("R3 first load at edge TOTAL+1", pin_o, '0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][2*N]) begin
        do_preload(VEC[i][2*N-1:N]);
        check("R6 preload round trip", pin_o, VEC[i][N-1:0]);
      end else begin
        oe_i = 1'b1; d_i = VEC[i][2*N-1:N];
        edges(1);
        check("R4 D load", pin_o, VEC[i][N-1:0]);
      end
    end

    // R5: hold while disabled
    oe_i = 1'b1; d_i = 10'h0F0; edges(1);
    oe_i = 1'b0; d_i = 10'h3C3; edges(4);
    check("R5 hold while disabled", pin_o, 10'h30F);
    check("R5 pin_oe low", pin_oe_o, '0);

    // R7: preload ignored while enabled
    oe_i = 1'b1; d_i = 10'h055; pin_i = 10'h055; preload_ni = 1'b0;
    edges(3); preload_ni = 1'b1; edges(SYNC + 3);
    check("R7 preload ignored with oe high", pin_o, 10'h3AA);

    // R1/R8: power loss clears, preload inside window ignored
    oe_i = 1'b0; pwr_good_i = 1'b0; edges(2);
    check("R1 power loss clears", pin_o, '1);
    pin_i = 10'h000; preload_ni = 1'b0; pwr_good_i = 1'b1;
    edges(RSTC - 3);
    preload_ni = 1'b1;  // rise lands before edge RSTC-2
    edges(SYNC + 3);
    check("R8 preload in window ignored", pin_o, '1);

    // R2: boundary, rise before edge RSTC-1 accepted
    pwr_good_i = 1'b0; edges(2);
    pin_i = 10'h2AA; preload_ni = 1'b0; pwr_good_i = 1'b1;
    edges(RSTC - 2);
    preload_ni = 1'b1;
    edges(SYNC + 3);
    check("R2 preload after window accepted", pin_o, 10'h2AA);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule